// File: doc/BRIEF.md
# Two-Bank Indirect Channel Configuration Register File

This block gives a host two byte-addressed ports into a pair of configuration banks, one bank per disk channel. The first port is an 8-bit pointer. The second port is a 16-bit data window. The pointer holds several fields: a bank select, a 3-bit register index, an optional post-access index advance, and three bus-timing control bits. The data window reads or writes the register that the pointer selects.

Each bank has seven registers:
- a command-block base address,
- a general configuration byte,
- a 10-bit read-ahead count split across two write-only registers,
- read-ahead control bits,
- a control-block base address,
- two timing bytes.

Every decoded field is exported as a registered output for use by the channel logic. Read-back hides write-only and undefined bits and returns 0 in their place. A FIFO-clear request is converted into a single-cycle strobe.

Top module: `cfg_regfile`

## Requirements
- R1: After a synchronous reset the pointer reads 0x50, which means wait-state bit 6 = 1, DEVSEL-medium bit 4 = 1, bank 0 and index 0. Bank 0 base addresses are 0x01F0 (index 0) and 0x03F6 (index 4). Bank 1 base addresses are 0x0170 and 0x0376. The general byte is 0x01, data timing is 0xF5, command timing is 0xDE, and the read-ahead count, read-ahead enable, mode-4 and FIFO-clear fields are all 0.
- R2: A pointer write stores the low byte of wdata. Bits 2..0 are the index, bit 3 selects the bank (0 = first channel), bit 6 drives wait_state_o, bit 5 drives burst_dis_o and bit 4 drives devsel_med_o. A pointer read returns the byte with bit 5 and bits 15..8 forced to 0.
- R3: When pointer bit 7 is 1, each data-port read or write advances the index by one after the access. When bit 7 is 0, the index does not change.
- R4: The index advance wraps from 6 to 0.
- R5: While the index is 7, data-port writes change no register, data-port reads return 0, and the pointer does not advance.
- R6: Indices 0 and 4 are 16-bit registers. A word write (wide = 1) loads all 16 bits. A byte write (wide = 0) changes only bits 7..0.
- R7: Index 1 is the general byte. On read-back bit 2 reads as 0, while gen_cfg_o exports all 8 written bits.
- R8: Index 2 supplies read-ahead count bits 7..0. Index 3 bits 1..0 supply count bits 9..8, bit 7 drives ra_en_o and bit 4 drives mode4_o. Reads of indices 2 and 3 return 0.
- R9: Writing index 3 with bit 6 set raises fifo_clr_o of that bank for exactly the one cycle after the write.
- R10: A data-port write changes only the bank that pointer bit 3 selects.
- R11: rdata shows the addressed value in the cycle after rd_en and holds it until the next read. For the byte-wide registers at indices 1, 2, 3, 5 and 6, bits 15..8 of rdata read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| port_sel | input | 1 | 0 = pointer port, 1 = data port |
| wide | input | 1 | 1 = 16-bit data access, 0 = byte access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| wait_state_o | output | 1 | Posted-write wait-state select |
| burst_dis_o | output | 1 | Master burst disable |
| devsel_med_o | output | 1 | DEVSEL medium timing select |
| cmd_base_o | output | 2x16 | Command-block base per bank |
| ctl_base_o | output | 2x16 | Control-block base per bank |
| gen_cfg_o | output | 2x8 | General configuration byte per bank |
| dtim_o | output | 2x8 | Data-port timing byte per bank |
| ctim_o | output | 2x8 | Command/control timing byte per bank |
| ra_count_o | output | 2x10 | Read-ahead count per bank |
| ra_en_o | output | 2 | Read-ahead enable per bank |
| fifo_clr_o | output | 2 | One-cycle FIFO clear strobe per bank |
| mode4_o | output | 2 | Mode-4 timing enable per bank |

## Verification
A wrong pointer index shows up at the very next data read. The value returned belongs to a neighbouring register, so a table of sequential auto-advancing reads exposes an off-by-one or a bad wrap within one access. A write that lands in the wrong bank, or misses the high byte, shows on the exported field outputs one cycle after the write. Masking faults show as nonzero bits in rdata one cycle after a read of a hidden field. A FIFO strobe that sticks is visible on the second cycle after the write.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;
  localparam int DW   = 16;
  localparam int BW   = 8;
  localparam int IW   = 3;
  localparam int NCH  = 2;
  localparam int RAW  = 10;
  localparam int LAST_IDX = 6;

  localparam logic [IW-1:0] IX_CMDB  = 3'd0;
  localparam logic [IW-1:0] IX_GEN   = 3'd1;
  localparam logic [IW-1:0] IX_RALO  = 3'd2;
  localparam logic [IW-1:0] IX_RACFG = 3'd3;
  localparam logic [IW-1:0] IX_CTLB  = 3'd4;
  localparam logic [IW-1:0] IX_DTIM  = 3'd5;
  localparam logic [IW-1:0] IX_CTIM  = 3'd6;
  localparam logic [IW-1:0] IX_NONE  = 3'd7;

  // pointer field positions
  localparam int P_AUTO  = 7;
  localparam int P_WAIT  = 6;
  localparam int P_BURST = 5;
  localparam int P_DSEL  = 4;
  localparam int P_BANK  = 3;

  localparam logic [BW-1:0] PTR_RD_MASK = 8'hDF;
  localparam logic [BW-1:0] GEN_RD_MASK = 8'hFB;
endpackage

// File: rtl/cfg_ptr.sv
module cfg_ptr import cfg_regfile_pkg::*; #(
  parameter logic [BW-1:0] PTR_DEF = 8'h50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [BW-1:0] wbyte,
  input  logic          adv,
  output logic [BW-1:0] ptr_q
);
  logic [IW-1:0] idx_next;

  always_comb begin
    if (ptr_q[IW-1:0] == IW'(LAST_IDX)) idx_next = '0;
    else                                 idx_next = ptr_q[IW-1:0] + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                    ptr_q <= PTR_DEF;
    else if (we)                ptr_q <= wbyte;
    else if (adv && ptr_q[P_AUTO]) ptr_q[IW-1:0] <= idx_next;
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank import cfg_regfile_pkg::*; #(
  parameter logic [DW-1:0] CMD_DEF  = 16'h01F0,
  parameter logic [DW-1:0] CTL_DEF  = 16'h03F6,
  parameter logic [BW-1:0] GEN_DEF  = 8'h01,
  parameter logic [BW-1:0] DTIM_DEF = 8'hF5,
  parameter logic [BW-1:0] CTIM_DEF = 8'hDE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic           wide,
  input  logic [IW-1:0]  idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rd_word,
  output logic [DW-1:0]  cmd_base,
  output logic [DW-1:0]  ctl_base,
  output logic [BW-1:0]  gen_cfg,
  output logic [BW-1:0]  dtim,
  output logic [BW-1:0]  ctim,
  output logic [RAW-1:0] ra_count,
  output logic           ra_en,
  output logic           fifo_clr,
  output logic           mode4
);
  localparam int RA_HI = RAW - BW;

  // merged value for a 16-bit register: byte access keeps the high byte
  function automatic logic [DW-1:0] merge16(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic w);
    return w ? nw : {old[DW-1:BW], nw[BW-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_base <= CMD_DEF;
      ctl_base <= CTL_DEF;
      gen_cfg  <= GEN_DEF;
      dtim     <= DTIM_DEF;
      ctim     <= CTIM_DEF;
      ra_count <= '0;
      ra_en    <= 1'b0;
      mode4    <= 1'b0;
      fifo_clr <= 1'b0;
    end else begin
      fifo_clr <= we && (idx == IX_RACFG) && wdata[6];
      if (we) begin
        case (idx)
          IX_CMDB:  cmd_base <= merge16(cmd_base, wdata, wide);
          IX_CTLB:  ctl_base <= merge16(ctl_base, wdata, wide);
          IX_GEN:   gen_cfg  <= wdata[BW-1:0];
          IX_DTIM:  dtim     <= wdata[BW-1:0];
          IX_CTIM:  ctim     <= wdata[BW-1:0];
          IX_RALO:  ra_count[BW-1:0] <= wdata[BW-1:0];
          IX_RACFG: begin
            ra_count[RAW-1:BW] <= wdata[RA_HI-1:0];
            ra_en <= wdata[7];
            mode4 <= wdata[4];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      IX_CMDB: rd_word = cmd_base;
      IX_CTLB: rd_word = ctl_base;
      IX_GEN:  rd_word = {{(DW-BW){1'b0}}, gen_cfg & GEN_RD_MASK};
      IX_DTIM: rd_word = {{(DW-BW){1'b0}}, dtim};
      IX_CTIM: rd_word = {{(DW-BW){1'b0}}, ctim};
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile import cfg_regfile_pkg::*; #(
  parameter logic [BW-1:0] PTR_DEF  = 8'h50,
  parameter logic [BW-1:0] GEN_DEF  = 8'h01,
  parameter logic [BW-1:0] DTIM_DEF = 8'hF5,
  parameter logic [BW-1:0] CTIM_DEF = 8'hDE,
  parameter logic [DW-1:0] CMD_DEF0 = 16'h01F0,
  parameter logic [DW-1:0] CMD_DEF1 = 16'h0170,
  parameter logic [DW-1:0] CTL_DEF0 = 16'h03F6,
  parameter logic [DW-1:0] CTL_DEF1 = 16'h0376
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     port_sel,
  input  logic                     wide,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     wait_state_o,
  output logic                     burst_dis_o,
  output logic                     devsel_med_o,
  output logic [NCH-1:0][DW-1:0]   cmd_base_o,
  output logic [NCH-1:0][DW-1:0]   ctl_base_o,
  output logic [NCH-1:0][BW-1:0]   gen_cfg_o,
  output logic [NCH-1:0][BW-1:0]   dtim_o,
  output logic [NCH-1:0][BW-1:0]   ctim_o,
  output logic [NCH-1:0][RAW-1:0]  ra_count_o,
  output logic [NCH-1:0]           ra_en_o,
  output logic [NCH-1:0]           fifo_clr_o,
  output logic [NCH-1:0]           mode4_o
);
  logic [BW-1:0]          ptr_q;
  logic [IW-1:0]          idx;
  logic                   bank;
  logic                   idx_ok;
  logic                   data_hit;
  logic [NCH-1:0][DW-1:0] bank_rd;

  assign idx      = ptr_q[IW-1:0];
  assign bank     = ptr_q[P_BANK];
  assign idx_ok   = (idx != IX_NONE);
  assign data_hit = (wr_en || rd_en) && port_sel && idx_ok;

  assign wait_state_o = ptr_q[P_WAIT];
  assign burst_dis_o  = ptr_q[P_BURST];
  assign devsel_med_o = ptr_q[P_DSEL];

  cfg_ptr #(.PTR_DEF(PTR_DEF)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en && !port_sel),
    .wbyte (wdata[BW-1:0]),
    .adv   (data_hit),
    .ptr_q (ptr_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_bank
    localparam logic [DW-1:0] CMD_D = (ch == 0) ? CMD_DEF0 : CMD_DEF1;
    localparam logic [DW-1:0] CTL_D = (ch == 0) ? CTL_DEF0 : CTL_DEF1;
    cfg_bank #(
      .CMD_DEF(CMD_D), .CTL_DEF(CTL_D), .GEN_DEF(GEN_DEF),
      .DTIM_DEF(DTIM_DEF), .CTIM_DEF(CTIM_DEF)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .we       (wr_en && port_sel && idx_ok && (bank == 1'(ch))),
      .wide     (wide),
      .idx      (idx),
      .wdata    (wdata),
      .rd_word  (bank_rd[ch]),
      .cmd_base (cmd_base_o[ch]),
      .ctl_base (ctl_base_o[ch]),
      .gen_cfg  (gen_cfg_o[ch]),
      .dtim     (dtim_o[ch]),
      .ctim     (ctim_o[ch]),
      .ra_count (ra_count_o[ch]),
      .ra_en    (ra_en_o[ch]),
      .fifo_clr (fifo_clr_o[ch]),
      .mode4    (mode4_o[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en) begin
      if (!port_sel)   rdata <= {{(DW-BW){1'b0}}, ptr_q & PTR_RD_MASK};
      else if (idx_ok) rdata <= bank_rd[bank];
      else             rdata <= '0;
    end
  end
endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk import cfg_regfile_pkg::*; (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           rd_en,
  input logic           port_sel,
  input logic [BW-1:0]  ptr_q,
  input logic [DW-1:0]  rdata,
  input logic [NCH-1:0] fifo_clr_o
);
  logic dacc;
  logic [IW-1:0] ix;
  assign dacc = (wr_en || rd_en) && port_sel;
  assign ix   = ptr_q[IW-1:0];

  AST_IDX7_FROZEN: assert property (@(posedge clk) disable iff (rst)
    dacc && ix == IX_NONE |=> $stable(ptr_q));                               // R5
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    dacc && ptr_q[P_AUTO] && ix == IW'(LAST_IDX) |=> ptr_q[IW-1:0] == '0);   // R4
  AST_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    dacc && !ptr_q[P_AUTO] |=> $stable(ptr_q));                              // R3
  AST_HIDDEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && port_sel && (ix == IX_RALO || ix == IX_RACFG || ix == IX_NONE)
    |=> rdata == '0);                                                        // R8
  AST_PTR_MASKED: assert property (@(posedge clk) disable iff (rst)
    rd_en && !port_sel |=> rdata[DW-1:BW] == '0 && !rdata[P_BURST]);        // R2
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
    rd_en && port_sel && ix != IX_CMDB && ix != IX_CTLB
    |=> rdata[DW-1:BW] == '0);                                               // R11
  AST_FIFO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    |fifo_clr_o |-> $past(wr_en && port_sel));                               // R9
  AST_FIFO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fifo_clr_o));                                                   // R10
endmodule

bind cfg_regfile cfg_regfile_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
  .ptr_q(ptr_q), .rdata(rdata), .fifo_clr_o(fifo_clr_o)
);

// File: tb/cfg_regfile_tb_top.sv
module cfg_regfile_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0, wide = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic wait_state_o, burst_dis_o, devsel_med_o;
  logic [1:0][15:0] cmd_base_o, ctl_base_o;
  logic [1:0][7:0]  gen_cfg_o, dtim_o, ctim_o;
  logic [1:0][9:0]  ra_count_o;
  logic [1:0]       ra_en_o, fifo_clr_o, mode4_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfg_regfile dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
    .wide(wide), .wdata(wdata), .rdata(rdata),
    .wait_state_o(wait_state_o), .burst_dis_o(burst_dis_o), .devsel_med_o(devsel_med_o),
    .cmd_base_o(cmd_base_o), .ctl_base_o(ctl_base_o), .gen_cfg_o(gen_cfg_o),
    .dtim_o(dtim_o), .ctim_o(ctim_o), .ra_count_o(ra_count_o),
    .ra_en_o(ra_en_o), .fifo_clr_o(fifo_clr_o), .mode4_o(mode4_o)
  );

  // entry: {is_read, data_port, wide, wdata, expected}
  localparam int NV = 30;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,16'h0080,16'h0000}, // R2 pointer: auto, bank0, idx0
    {1'b1,1'b0,1'b0,16'h0000,16'h0080}, // R2
    {1'b0,1'b1,1'b1,16'h1234,16'h0000}, // R6 idx0 word
    {1'b0,1'b1,1'b0,16'h00A7,16'h0000}, // R7 idx1
    {1'b0,1'b1,1'b0,16'h0055,16'h0000}, // R8 idx2
    {1'b0,1'b1,1'b0,16'h00D2,16'h0000}, // R8 idx3
    {1'b0,1'b1,1'b1,16'hBEEF,16'h0000}, // R6 idx4 word
    {1'b0,1'b1,1'b0,16'h0011,16'h0000}, // idx5
    {1'b0,1'b1,1'b0,16'h0022,16'h0000}, // R4 idx6 then wrap
    {1'b1,1'b1,1'b0,16'h0000,16'h1234}, // R4 wrapped to idx0
    {1'b1,1'b1,1'b0,16'h0000,16'h00A3}, // R7 bit2 hidden
    {1'b1,1'b1,1'b0,16'h0000,16'h0000}, // R8 idx2 reads 0
    {1'b1,1'b1,1'b0,16'h0000,16'h0000}, // R8 idx3 reads 0
    {1'b1,1'b1,1'b0,16'h0000,16'hBEEF}, // R3
    {1'b1,1'b1,1'b0,16'h0000,16'h0011}, // R11
    {1'b1,1'b1,1'b0,16'h0000,16'h0022}, // R11
    {1'b0,1'b0,1'b0,16'h008C,16'h0000}, // R2 bank1 idx4
    {1'b1,1'b0,1'b0,16'h0000,16'h008C}, // R2
    {1'b1,1'b1,1'b0,16'h0000,16'h0376}, // R10 bank1 untouched
    {1'b1,1'b1,1'b0,16'h0000,16'h00F5}, // R1
    {1'b1,1'b1,1'b0,16'h0000,16'h00DE}, // R1
    {1'b1,1'b1,1'b0,16'h0000,16'h0170}, // R10
    {1'b1,1'b1,1'b0,16'h0000,16'h0001}, // R1
    {1'b0,1'b0,1'b0,16'h0020,16'h0000}, // R2 burst bit, no auto
    {1'b1,1'b0,1'b0,16'h0000,16'h0000}, // R2 burst bit hidden
    {1'b0,1'b1,1'b0,16'h0077,16'h0000}, // R6 byte write idx0
    {1'b1,1'b1,1'b0,16'h0000,16'h1277}, // R6
    {1'b1,1'b1,1'b0,16'h0000,16'h1277}, // R3 no advance
    {1'b0,1'b1,1'b1,16'hABCD,16'h0000}, // R6 word write
    {1'b1,1'b1,1'b0,16'h0000,16'hABCD}  // R6
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic ps, input logic wd, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; port_sel = ps; wide = wd; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wide = 1'b0;
  endtask

  task automatic do_rd(input logic ps);
    @(negedge clk);
    rd_en = 1'b1; port_sel = ps;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cmd0", cmd_base_o[0], 16'h01F0);
    chk("R1 ctl1", ctl_base_o[1], 16'h0376);
    chk("R1 gen0", {8'h0, gen_cfg_o[0]}, 16'h0001);
    chk("R1 dtim1", {8'h0, dtim_o[1]}, 16'h00F5);
    chk("R1 ctim0", {8'h0, ctim_o[0]}, 16'h00DE);
    chk("R1 ra", {6'h0, ra_count_o[1]}, 16'h0000);
    chk("R1 flags", {12'h0, ra_en_o, mode4_o}, 16'h0000);
    chk("R1 ptr bits", {13'h0, wait_state_o, burst_dis_o, devsel_med_o}, 16'h0005);
    do_rd(1'b0);
    chk("R1 ptr", rdata, 16'h0050);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][34]) begin
        do_rd(VEC[i][33]);
        chk($sformatf("table[%0d]", i), rdata, VEC[i][15:0]);
      end else begin
        do_wr(VEC[i][33], VEC[i][32], VEC[i][31:16]);
      end
    end

    chk("R2 burst_dis_o", {15'h0, burst_dis_o}, 16'h0001);
    chk("R2 devsel_med_o", {15'h0, devsel_med_o}, 16'h0000);
    chk("R7 gen export", {8'h0, gen_cfg_o[0]}, 16'h00A7);
    chk("R8 ra count", {6'h0, ra_count_o[0]}, 16'h0255);
    chk("R8 ra_en mode4", {14'h0, ra_en_o[0], mode4_o[0]}, 16'h0003);
    chk("R6 ctl0", ctl_base_o[0], 16'hBEEF);
    chk("R10 cmd1", cmd_base_o[1], 16'h0170);

    // R6 byte write into the control base keeps the high byte
    do_wr(1'b0, 1'b0, 16'h0004);
    do_wr(1'b1, 1'b0, 16'h995A);
    chk("R6 byte ctl0", ctl_base_o[0], 16'hBE5A);

    // R9 FIFO clear strobe
    do_wr(1'b0, 1'b0, 16'h0003);
    do_wr(1'b1, 1'b0, 16'h0040);
    chk("R9 strobe high", {14'h0, fifo_clr_o}, 16'h0001);
    @(negedge clk);
    chk("R9 strobe low", {14'h0, fifo_clr_o}, 16'h0000);
    chk("R8 ra cleared", {5'h0, ra_en_o[0], ra_count_o[0]}, 16'h0055);

    // R5 index 7
    do_wr(1'b0, 1'b0, 16'h0087);
    do_wr(1'b1, 1'b1, 16'hFFFF);
    do_rd(1'b1);
    chk("R5 read zero", rdata, 16'h0000);
    do_rd(1'b0);
    chk("R5 no advance", rdata, 16'h0087);
    chk("R5 cmd0 kept", cmd_base_o[0], 16'hABCD);
    chk("R5 ctl0 kept", ctl_base_o[0], 16'hBE5A);
    chk("R5 bank1 kept", cmd_base_o[1], 16'h0170);

    // R11 rdata holds between reads
    repeat (2) @(negedge clk);
    chk("R11 hold", rdata, 16'h0087);

    finish_run();
  end
endmodule